// File: doc/BRIEF.md
# Byte-Wide SPI Master Peripheral

This block is a register-mapped serial-peripheral-interface master that moves one 8-bit word at a time in full duplex. A processor reaches it through a simple byte-wide slave port and sets the clock polarity, the clock phase and the bit rate there. It writes a byte to start an exchange and reads the received byte back once the block reports completion, either by polling a status flag or by taking an interrupt.

The serial clock is derived from the system clock through an 8-bit prescaler. Each half period of SCK lasts `PRE+1` system clocks, so SCK runs at `clk / (2*(PRE+1))`. A separate enable bit gates SCK. While that bit is clear, no SCK edges appear and a running exchange waits. The chip-select output comes straight from a register, and its active level can be chosen. A write to the transmit register while an exchange is still running is flagged as a collision, and the byte from that write is discarded.

Top module: `spi_byte_master`

## Requirements
- R1: Register offsets are: control 0, prescaler 1, status 2, chip-select 3, transmit 4, receive 5. After reset the control register reads 0x00, the prescaler reads 0xFF, status reads 0x00, the chip-select register reads 0x00, SCK is low and irq_o is low.
- R2: A write to offset 4 while idle starts an 8-bit exchange. Every SCK half period lasts PRE+1 clocks, so completion falls exactly 16*(PRE+1) clock edges after the write edge.
- R3: SCK rests at the CPOL level (control bit 1) whenever no exchange is running. One exchange produces exactly 8 SCK pulses, which is 16 transitions.
- R4: While SCK enable (control bit 0) is clear, SCK does not change and a running exchange stalls. Setting the bit again resumes the exchange, and it completes with the correct data.
- R5: Bits leave MSB first. With CPHA (control bit 2) clear, the first bit is on MOSI before the first SCK edge, MISO is sampled on leading edges and MOSI changes on trailing edges. With CPHA set, MOSI changes on leading edges and MISO is sampled on trailing edges. The received byte reads back at offset 5.
- R6: The ready flag (status bit 0) is set when an exchange completes. A write to offset 4 or a read of offset 5 clears it.
- R7: A write to offset 4 during an exchange sets the collision flag (status bit 1), discards the written byte and leaves the exchange running. A read of the status register clears the collision flag.
- R8: irq_o is high exactly when the ready flag is set and the interrupt-mode bit (control bit 4) is set.
- R9: Chip-select register bit 0 asserts select, and bit 1 chooses active-high. cs_o equals bit 1 when bit 0 is set and the inverse of bit 1 otherwise.
- R10: After an exchange, MOSI holds the last bit it sent, the LSB of the transmitted byte, until the next exchange starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register, combinational |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 1 | Chip select |
| irq_o | output | 1 | Exchange-complete interrupt |

## Verification
Completion is registered on the same edge as the sixteenth SCK transition. The bench therefore counts 16*(PRE+1)-1 edges after the transmit write and expects irq_o low, then expects it high one edge later. Flag updates caused by register accesses show up one cycle after the access edge. Serial data is captured by the bench on the SCK edge that the chosen phase defines. Every output is sampled one time unit after a rising edge, once all registers have settled, and the bus drives its inputs on falling edges.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;
   localparam int unsigned REG_CTRL = 0;
   localparam int unsigned REG_BAUD = 1;
   localparam int unsigned REG_STAT = 2;
   localparam int unsigned REG_PINS = 3;
   localparam int unsigned REG_TXD  = 4;
   localparam int unsigned REG_RXD  = 5;

   typedef struct packed {
      logic irq_en;
      logic master;
      logic cpha;
      logic cpol;
      logic sck_en;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/spi_bm_baud.sv
module spi_bm_baud #(
   parameter int unsigned PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [PRE_W-1:0] pre,
   output logic             tick
);
   logic [PRE_W-1:0] cnt_q;
   logic             wrap;

   assign wrap = (cnt_q == pre);
   assign tick = run & wrap & ~restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (run)     cnt_q <= wrap ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/spi_bm_shifter.sv
module spi_bm_shifter #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              cpha,
   input  logic              tick,
   input  logic              miso_i,
   output logic              busy,
   output logic              done,
   output logic              sck_lvl,
   output logic              mosi,
   output logic [DATA_W-1:0] rx_byte
);
   localparam int unsigned EDGES = 2 * DATA_W;
   localparam int unsigned EW    = $clog2(EDGES);
   localparam int unsigned MSB   = DATA_W - 1;

   logic [EW-1:0]     edge_q;
   logic [DATA_W-1:0] txs_q, rxs_q;
   logic              leading, sample_now, drive_now, last_edge;
   logic [DATA_W-1:0] rx_next;

   assign leading    = ~edge_q[0];
   assign sample_now = leading ^ cpha;
   assign last_edge  = (edge_q == EW'(EDGES - 1));
   assign drive_now  = ~sample_now & ~last_edge;
   assign rx_next    = sample_now ? {rxs_q[DATA_W-2:0], miso_i} : rxs_q;
   assign done       = busy & tick & last_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         edge_q  <= '0;
         sck_lvl <= 1'b0;
         mosi    <= 1'b0;
         txs_q   <= '0;
         rxs_q   <= '0;
         rx_byte <= '0;
      end else if (start) begin
         busy    <= 1'b1;
         edge_q  <= '0;
         sck_lvl <= 1'b0;
         rxs_q   <= '0;
         if (!cpha) begin
            mosi  <= tx_byte[MSB];
            txs_q <= {tx_byte[DATA_W-2:0], 1'b0};
         end else begin
            txs_q <= tx_byte;
         end
      end else if (busy && tick) begin
         sck_lvl <= ~sck_lvl;
         edge_q  <= edge_q + 1'b1;
         if (sample_now) rxs_q <= {rxs_q[DATA_W-2:0], miso_i};
         if (drive_now) begin
            mosi  <= txs_q[MSB];
            txs_q <= {txs_q[DATA_W-2:0], 1'b0};
         end
         if (last_edge) begin
            busy    <= 1'b0;
            rx_byte <= rx_next;
         end
      end
   end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
   import spi_bm_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PRE_W  = 8,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              sck_o,
   output logic              mosi_o,
   input  logic              miso_i,
   output logic              cs_o,
   output logic              irq_o
);
   generate
      if (DATA_W < CTRL_W) begin : g_bad_data
         $error("DATA_W must hold the control fields");
      end
      if (PRE_W > DATA_W || PRE_W < 1) begin : g_bad_pre
         $error("PRE_W must be between 1 and DATA_W");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must reach six registers");
      end
   endgenerate

   ctrl_t             ctrl_q;
   logic [PRE_W-1:0]  pre_q;
   logic [1:0]        pins_q;
   logic              ready_q, coll_q;
   logic              wr_en, rd_en, tx_wr, stat_rd, rx_rd, start;
   logic              eng_busy, eng_done, eng_tick, sck_lvl;
   logic              sck_en_w, cpol_w;
   logic [DATA_W-1:0] rx_data;

   assign wr_en   = bus_sel & bus_wr;
   assign rd_en   = bus_sel & ~bus_wr;
   assign tx_wr   = wr_en & (bus_addr == ADDR_W'(REG_TXD));
   assign stat_rd = rd_en & (bus_addr == ADDR_W'(REG_STAT));
   assign rx_rd   = rd_en & (bus_addr == ADDR_W'(REG_RXD));
   assign start   = tx_wr & ~eng_busy;
   assign sck_en_w = ctrl_q.sck_en;
   assign cpol_w   = ctrl_q.cpol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         pre_q  <= '1;
         pins_q <= '0;
      end else if (wr_en) begin
         case (bus_addr)
            ADDR_W'(REG_CTRL): ctrl_q <= bus_wdata[CTRL_W-1:0];
            ADDR_W'(REG_BAUD): pre_q  <= bus_wdata[PRE_W-1:0];
            ADDR_W'(REG_PINS): pins_q <= bus_wdata[1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         coll_q  <= 1'b0;
      end else begin
         if (tx_wr || rx_rd) ready_q <= 1'b0;
         if (eng_done)       ready_q <= 1'b1;
         if (stat_rd)        coll_q  <= 1'b0;
         if (tx_wr && eng_busy) coll_q <= 1'b1;
      end
   end

   spi_bm_baud #(.PRE_W(PRE_W)) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (start),
      .run     (eng_busy & sck_en_w),
      .pre     (pre_q),
      .tick    (eng_tick)
   );

   spi_bm_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .tx_byte (bus_wdata),
      .cpha    (ctrl_q.cpha),
      .tick    (eng_tick),
      .miso_i  (miso_i),
      .busy    (eng_busy),
      .done    (eng_done),
      .sck_lvl (sck_lvl),
      .mosi    (mosi_o),
      .rx_byte (rx_data)
   );

   assign sck_o = cpol_w ^ sck_lvl;
   assign cs_o  = pins_q[0] ? pins_q[1] : ~pins_q[1];
   assign irq_o = ready_q & ctrl_q.irq_en;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(REG_CTRL): bus_rdata[CTRL_W-1:0] = ctrl_q;
         ADDR_W'(REG_BAUD): bus_rdata[PRE_W-1:0]  = pre_q;
         ADDR_W'(REG_STAT): bus_rdata[1:0]        = {coll_q, ready_q};
         ADDR_W'(REG_PINS): bus_rdata[1:0]        = pins_q;
         ADDR_W'(REG_RXD):  bus_rdata             = rx_data;
         default:           bus_rdata             = '0;
      endcase
   end
endmodule

// File: rtl/spi_bm_checker.sv
module spi_bm_checker (
   input logic clk,
   input logic rst_n,
   input logic tx_wr,
   input logic stat_rd,
   input logic rx_rd,
   input logic eng_busy,
   input logic eng_done,
   input logic sck_en,
   input logic cpol,
   input logic sck_lvl,
   input logic sck_o,
   input logic ready,
   input logic coll,
   input logic irq_o
);
   // R2: a transmit write while idle starts an exchange
   a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && !eng_busy) |=> eng_busy);

   // R3: idle SCK sits at the polarity level
   a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_busy |-> (sck_o == cpol));

   // R4: no SCK movement while the enable is clear
   a_r4_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sck_en |=> $stable(sck_lvl));

   // R6: completion sets ready, a receive read clears it
   a_r6_ready_set: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> ready);
   a_r6_ready_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && !eng_done) |=> !ready);

   // R7: collision set on a busy write, cleared by a status read
   a_r7_coll_set: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && eng_busy) |=> coll);
   a_r7_coll_clear: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> !coll);

   // R8: interrupt only with ready
   a_r8_irq_ready: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ready);
endmodule

bind spi_byte_master spi_bm_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tx_wr    (tx_wr),
   .stat_rd  (stat_rd),
   .rx_rd    (rx_rd),
   .eng_busy (eng_busy),
   .eng_done (eng_done),
   .sck_en   (sck_en_w),
   .cpol     (cpol_w),
   .sck_lvl  (sck_lvl),
   .sck_o    (sck_o),
   .ready    (ready_q),
   .coll     (coll_q),
   .irq_o    (irq_o)
);

// File: tb/spi_byte_master_tb.sv
module spi_byte_master_tb;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic       cpol;
      logic       cpha;
      logic [7:0] pre;
      logic [7:0] tx;
      logic       inv;
      logic [7:0] exp_rx;
   } vec_t;

   localparam vec_t VEC [0:5] = '{
      '{1'b0, 1'b0, 8'd0, 8'hA5, 1'b0, 8'hA5},
      '{1'b0, 1'b1, 8'd1, 8'h3C, 1'b1, 8'hC3},
      '{1'b1, 1'b0, 8'd2, 8'h81, 1'b0, 8'h81},
      '{1'b1, 1'b1, 8'd0, 8'h7E, 1'b1, 8'h81},
      '{1'b0, 1'b0, 8'd3, 8'h01, 1'b1, 8'hFE},
      '{1'b1, 1'b1, 8'd1, 8'hF0, 1'b0, 8'hF0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       sck_o, mosi_o, miso_i, cs_o, irq_o;

   logic       inv_b = 1'b0, cpol_b = 1'b0, cpha_b = 1'b0, mon_en = 1'b0;
   logic [7:0] cap;
   int         edges;
   int         checks = 0, errors = 0;
   bit         finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign miso_i = mosi_o ^ inv_b;

   spi_byte_master u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .cs_o(cs_o), .irq_o(irq_o)
   );

   // bench-side slave: capture MOSI on the sampling edge of the chosen phase
   always @(sck_o) begin
      if (mon_en) begin
         edges = edges + 1;
         if ((sck_o != cpol_b) ^ cpha_b) cap = {cap[6:0], mosi_o};
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk);
      #1 bus_sel = 1'b0;
   endtask

   task automatic wait_irq(input int limit, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < limit && !seen; i++) begin
         @(posedge clk); #1;
         if (irq_o) seen = 1'b1;
      end
   endtask

   function automatic logic [7:0] ctl(input logic irq_en, input logic cpha,
                                      input logic cpol, input logic en);
      return {3'b000, irq_en, 1'b1, cpha, cpol, en};
   endfunction

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      summary();
   end

   initial begin
      logic [7:0] rd;
      bit         seen;
      logic       hold;
      int         n;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      bus_read(3'd0, rd); check(rd == 8'h00, "R1 ctrl reset", rd, 8'h00);
      bus_read(3'd1, rd); check(rd == 8'hFF, "R1 prescaler reset", rd, 8'hFF);
      bus_read(3'd2, rd); check(rd == 8'h00, "R1 status reset", rd, 8'h00);
      bus_read(3'd3, rd); check(rd == 8'h00, "R1 pins reset", rd, 8'h00);
      check(sck_o == 1'b0 && irq_o == 1'b0, "R1 sck/irq reset", {sck_o, irq_o}, 0);
      check(cs_o == 1'b1, "R9 cs idle at reset", cs_o, 1);

      // R9 chip-select polarity
      bus_write(3'd3, 8'h01); check(cs_o == 1'b0, "R9 active-low assert", cs_o, 0);
      bus_write(3'd3, 8'h03); check(cs_o == 1'b1, "R9 active-high assert", cs_o, 1);
      bus_write(3'd3, 8'h02); check(cs_o == 1'b0, "R9 active-high idle", cs_o, 0);
      bus_write(3'd3, 8'h00);

      // vector table: modes, prescalers, data patterns
      foreach (VEC[k]) begin
         vec_t v;
         v = VEC[k];
         cpol_b = v.cpol; cpha_b = v.cpha; inv_b = v.inv;
         bus_write(3'd0, ctl(1'b1, v.cpha, v.cpol, 1'b1));
         check(sck_o == v.cpol, "R3 idle level follows cpol", sck_o, v.cpol);
         bus_write(3'd1, v.pre);
         bus_write(3'd3, 8'h01);
         cap = '0; edges = 0; mon_en = 1'b1;
         n = 16 * (int'(v.pre) + 1);
         bus_write(3'd4, v.tx);
         if (!v.cpha) check(mosi_o == v.tx[7], "R5 first bit before first edge", mosi_o, v.tx[7]);
         repeat (n - 1) @(posedge clk);
         #1 check(irq_o == 1'b0, "R2 not done one edge early", irq_o, 0);
         @(posedge clk);
         #1 check(irq_o == 1'b1, "R2 done at 16*(PRE+1)", irq_o, 1);
         mon_en = 1'b0;
         check(edges == 16, "R3 sixteen transitions", edges, 16);
         check(cap == v.tx, "R5 MSB-first transmit", cap, v.tx);
         check(sck_o == v.cpol, "R3 rest after exchange", sck_o, v.cpol);
         check(mosi_o == v.tx[0], "R10 MOSI holds last bit", mosi_o, v.tx[0]);
         bus_read(3'd5, rd);
         check(rd == v.exp_rx, "R5 received byte", rd, v.exp_rx);
         check(irq_o == 1'b0, "R6 rx read clears ready", irq_o, 0);
         bus_write(3'd3, 8'h00);
      end

      // R7 collision
      cpol_b = 1'b0; cpha_b = 1'b0; inv_b = 1'b0;
      bus_write(3'd0, ctl(1'b1, 1'b0, 1'b0, 1'b1));
      bus_write(3'd1, 8'd3);
      bus_write(3'd4, 8'h3C);
      repeat (5) @(posedge clk);
      bus_write(3'd4, 8'h55);
      bus_read(3'd2, rd); check(rd == 8'h02, "R7 collision flagged", rd, 8'h02);
      bus_read(3'd2, rd); check(rd == 8'h00, "R7 status read clears", rd, 8'h00);
      wait_irq(200, seen); check(seen, "R7 exchange continues", seen, 1);
      bus_read(3'd5, rd); check(rd == 8'h3C, "R7 colliding byte discarded", rd, 8'h3C);

      // R6 ready cleared by a new transmit write
      bus_write(3'd1, 8'd0);
      bus_write(3'd4, 8'h11);
      wait_irq(100, seen);
      bus_read(3'd2, rd); check(rd == 8'h01, "R6 ready set", rd, 8'h01);
      bus_write(3'd4, 8'h22);
      check(irq_o == 1'b0, "R6 tx write clears ready", irq_o, 0);
      wait_irq(100, seen);
      bus_read(3'd5, rd); check(rd == 8'h22, "R6 second exchange data", rd, 8'h22);

      // R8 polled mode: no interrupt although ready
      bus_write(3'd0, ctl(1'b0, 1'b0, 1'b0, 1'b1));
      bus_write(3'd4, 8'h5A);
      repeat (40) @(posedge clk);
      #1 check(irq_o == 1'b0, "R8 irq masked", irq_o, 0);
      bus_read(3'd2, rd); check(rd == 8'h01, "R8 ready visible by polling", rd, 8'h01);
      bus_write(3'd0, ctl(1'b1, 1'b0, 1'b0, 1'b1));
      check(irq_o == 1'b1, "R8 irq on enabling with ready", irq_o, 1);
      bus_read(3'd5, rd);

      // R4 SCK gating stalls the exchange
      inv_b = 1'b1;
      bus_write(3'd1, 8'd1);
      bus_write(3'd4, 8'hC6);
      repeat (7) @(posedge clk);
      bus_write(3'd0, ctl(1'b1, 1'b0, 1'b0, 1'b0));
      #1 hold = sck_o;
      n = 0;
      for (int i = 0; i < 40; i++) begin
         @(posedge clk); #1;
         if (sck_o != hold || irq_o) n++;
      end
      check(n == 0, "R4 no edges while disabled", n, 0);
      bus_write(3'd0, ctl(1'b1, 1'b0, 1'b0, 1'b1));
      wait_irq(200, seen); check(seen, "R4 resumes when enabled", seen, 1);
      bus_read(3'd5, rd); check(rd == 8'h39, "R4 data intact after stall", rd, 8'h39);

      summary();
   end
endmodule